// File: doc/BRIEF.md
# Edge-Selectable Maskable Interrupt Controller

This block collects interrupt requests for a small 4-bit controller core. The sources are two 4-bit input pin groups and three internal pulse sources. The internal sources are a prescaler tick, a timer-zero event and a serial-buffer-empty event. Each pin is first registered. It can then be routed through a debouncer clocked by a slow sample strobe, or used direct. A per-pin polarity bit picks whether a rising or a falling transition counts. Each qualifying event sets a sticky request flag.

Flags are grouped into three 4-bit flag registers. Reading a flag register returns its contents, and the read also clears those flags as a side effect. There is no separate acknowledge write. A per-source mask decides which flags drive the CPU interrupt line. The same line doubles as the wake request that releases the core from its halted standby state. For the prescaler source, a rate field picks which of three prescaler tick outputs (1 Hz, 8 Hz, 32 Hz) may raise requests.

Top module: `irq_hub`

## Requirements
- R1: After synchronous reset, every register reads 0: flags, masks, polarity (all rising), debounce enables (all direct), and rate (1 Hz). `cpu_irq` and `wake_req` are low.
- R2: With debounce disabled, a pin sets its flag two clock edges after it changes. A polarity bit of 0 selects the rising edge and 1 selects the falling edge. The opposite edge sets nothing.
- R3: With debounce enabled, a pin's level is only accepted after 3 consecutive `deb_tick` samples agree. A level held for fewer samples sets no flag. The debounced level changes only on cycles with `deb_tick` high.
- R4: A set flag stays set, however long, until its flag register is read.
- R5: Asserting `reg_rd` at a flag address shows the flags on `reg_rdata` in that same cycle. Those flags are cleared at the following clock edge.
- R6: If an event arrives in the same cycle as a clearing read of its register, the flag is left set after that read.
- R7: The internal flag register is at address 2. Bit 0 is the prescaler source, bit 1 is `timer_zero` and bit 2 is `sbuf_empty`. Bit 3 reads 0. Each source sets its flag when its input is high at a clock edge.
- R8: The rate field at address 12 selects the prescaler tick: 0 selects `tick_1hz`, 1 selects `tick_8hz`, 2 selects `tick_32hz`, and 3 selects none. Ticks that are not selected have no effect.
- R9: `cpu_irq` is high exactly when some flag is set and its mask bit is 1. A masked flag is still latched and still readable.
- R10: `wake_req` always equals `cpu_irq`.
- R11: The register map is as follows. Flags are at 0 (group A), 1 (group B) and 2 (internal). Masks are at 4, 5 and 6 (3 bits). Polarity is at 8 and 9. Debounce enables are at 10 and 11. Rate is at 12 (2 bits). Control registers read back what was written. Writes to flag addresses are ignored. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deb_tick | input | 1 | Debounce sample strobe |
| pins_a | input | 4 | Pin group A |
| pins_b | input | 4 | Pin group B |
| tick_1hz | input | 1 | Prescaler 1 Hz tick pulse |
| tick_8hz | input | 1 | Prescaler 8 Hz tick pulse |
| tick_32hz | input | 1 | Prescaler 32 Hz tick pulse |
| timer_zero | input | 1 | Timer reached zero pulse |
| sbuf_empty | input | 1 | Serial buffer empty pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags at flag addresses) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data, combinational from address |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| wake_req | output | 1 | Wake request from standby |

## Verification
The bench builds the block with its default debounce length of three samples. This keeps the glitch-rejection window short enough to reach directly. The bench can show that two ticks are rejected and the third accepts, and that a two-tick glitch leaves no trace. Group A is driven through the debounced path and group B through the direct path. Fixed-seed random pin patterns on group B, with random polarity and masks, cover every combination of edge direction and masking per pin. Directed sequences place an event in the exact cycle of a clearing read.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int PORT_W  = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 4;
    localparam int INT_W   = 3;
    localparam int N_GRP   = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_FLAG_A   = 4'd0,
        A_FLAG_B   = 4'd1,
        A_FLAG_INT = 4'd2,
        A_MASK_A   = 4'd4,
        A_MASK_B   = 4'd5,
        A_MASK_INT = 4'd6,
        A_POL_A    = 4'd8,
        A_POL_B    = 4'd9,
        A_DEB_A    = 4'd10,
        A_DEB_B    = 4'd11,
        A_RATE     = 4'd12
    } reg_addr_e;

    typedef enum logic [1:0] {
        RATE_1HZ  = 2'd0,
        RATE_8HZ  = 2'd1,
        RATE_32HZ = 2'd2,
        RATE_OFF  = 2'd3
    } rate_e;

    typedef struct packed {
        logic [PORT_W-1:0] mask;
        logic [PORT_W-1:0] pol;
        logic [PORT_W-1:0] deb;
    } grp_cfg_t;

    typedef struct packed {
        logic sbuf;
        logic timer;
        logic presc;
    } int_src_t;

    function automatic logic rate_pick(rate_e r, logic t1, logic t8, logic t32);
        case (r)
            RATE_1HZ:  return t1;
            RATE_8HZ:  return t8;
            RATE_32HZ: return t32;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_debounce.sv
module irq_debounce #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    output logic dout
);
    logic [LEN-1:0] hist;
    logic [LEN-1:0] hist_nx;

    assign hist_nx = {hist[LEN-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            dout <= 1'b0;
        end else if (tick) begin
            hist <= hist_nx;
            if (&hist_nx)
                dout <= 1'b1;
            else if (~|hist_nx)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    input  logic deb_en,
    input  logic pol,
    output logic set_pulse,
    output logic deb_q
);
    logic pin_q;
    logic cond;
    logic cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            cond_q <= 1'b0;
        end else begin
            pin_q  <= pin;
            cond_q <= cond;
        end
    end

    irq_debounce #(.LEN(LEN)) u_deb (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .din  (pin_q),
        .dout (deb_q)
    );

    assign cond      = deb_en ? deb_q : pin_q;
    assign set_pulse = pol ? (cond_q & ~cond) : (cond & ~cond_q);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr,
    output logic [W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else if (clr)
            flags <= set;
        else
            flags <= flags | set;
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_pkg::*;
#(
    parameter int DEB_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              deb_tick,
    input  logic [PORT_W-1:0] pins_a,
    input  logic [PORT_W-1:0] pins_b,
    input  logic              tick_1hz,
    input  logic              tick_8hz,
    input  logic              tick_32hz,
    input  logic              timer_zero,
    input  logic              sbuf_empty,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cpu_irq,
    output logic              wake_req
);
    grp_cfg_t [N_GRP-1:0]              cfg;
    logic     [INT_W-1:0]              mask_int;
    rate_e                             rate;
    logic     [N_GRP-1:0][PORT_W-1:0]  pins_g;
    logic     [N_GRP-1:0][PORT_W-1:0]  set_g;
    logic     [N_GRP-1:0][PORT_W-1:0]  deb_g;
    logic     [N_GRP-1:0][PORT_W-1:0]  flags_g;
    logic     [N_GRP-1:0]              clr_g;
    int_src_t                          int_set;
    logic     [INT_W-1:0]              flags_int;
    logic                              clr_int;

    assign pins_g = {pins_b, pins_a};

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= '0;
            mask_int <= '0;
            rate     <= RATE_1HZ;
        end else if (reg_wr) begin
            case (reg_addr)
                A_MASK_A:   cfg[0].mask <= reg_wdata;
                A_MASK_B:   cfg[1].mask <= reg_wdata;
                A_MASK_INT: mask_int    <= reg_wdata[INT_W-1:0];
                A_POL_A:    cfg[0].pol  <= reg_wdata;
                A_POL_B:    cfg[1].pol  <= reg_wdata;
                A_DEB_A:    cfg[0].deb  <= reg_wdata;
                A_DEB_B:    cfg[1].deb  <= reg_wdata;
                A_RATE:     rate        <= rate_e'(reg_wdata[1:0]);
                default: ;
            endcase
        end
    end

    // pin groups: conditioning per pin, one flag bank per group
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar i = 0; i < PORT_W; i++) begin : g_pin
            irq_pin_cond #(.LEN(DEB_LEN)) u_pin (
                .clk       (clk),
                .rst       (rst),
                .tick      (deb_tick),
                .pin       (pins_g[g][i]),
                .deb_en    (cfg[g].deb[i]),
                .pol       (cfg[g].pol[i]),
                .set_pulse (set_g[g][i]),
                .deb_q     (deb_g[g][i])
            );
        end

        assign clr_g[g] = reg_rd &&
            (reg_addr == ((g == 0) ? A_FLAG_A : A_FLAG_B));

        irq_flag_bank #(.W(PORT_W)) u_flags (
            .clk   (clk),
            .rst   (rst),
            .set   (set_g[g]),
            .clr   (clr_g[g]),
            .flags (flags_g[g])
        );
    end

    // internal sources
    assign int_set.presc = rate_pick(rate, tick_1hz, tick_8hz, tick_32hz);
    assign int_set.timer = timer_zero;
    assign int_set.sbuf  = sbuf_empty;
    assign clr_int       = reg_rd && (reg_addr == A_FLAG_INT);

    irq_flag_bank #(.W(INT_W)) u_int_flags (
        .clk   (clk),
        .rst   (rst),
        .set   (int_set),
        .clr   (clr_int),
        .flags (flags_int)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_FLAG_A:   reg_rdata = flags_g[0];
            A_FLAG_B:   reg_rdata = flags_g[1];
            A_FLAG_INT: reg_rdata = {1'b0, flags_int};
            A_MASK_A:   reg_rdata = cfg[0].mask;
            A_MASK_B:   reg_rdata = cfg[1].mask;
            A_MASK_INT: reg_rdata = {1'b0, mask_int};
            A_POL_A:    reg_rdata = cfg[0].pol;
            A_POL_B:    reg_rdata = cfg[1].pol;
            A_DEB_A:    reg_rdata = cfg[0].deb;
            A_DEB_B:    reg_rdata = cfg[1].deb;
            A_RATE:     reg_rdata = {2'b00, rate};
            default:    reg_rdata = '0;
        endcase
    end

    assign cpu_irq  = (|(flags_g[0] & cfg[0].mask)) |
                      (|(flags_g[1] & cfg[1].mask)) |
                      (|(flags_int  & mask_int));
    assign wake_req = cpu_irq;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_rd,
    input logic [3:0] reg_addr,
    input logic       deb_tick,
    input logic [3:0] set_a,
    input logic [3:0] flags_a,
    input logic [3:0] flags_b,
    input logic [3:0] deb_a,
    input logic [3:0] deb_b,
    input logic [3:0] mask_a,
    input logic [3:0] mask_b,
    input logic [2:0] mask_int,
    input logic       cpu_irq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (flags_a == 4'd0 && flags_b == 4'd0 && !cpu_irq));

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_addr == 4'd0) |=> ((flags_a & $past(flags_a)) == $past(flags_a)));

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 4'd0 && set_a == 4'd0) |=> (flags_a == 4'd0));

    // R6
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_a) |=> ((flags_a & $past(set_a)) == $past(set_a)));

    // R3
    deb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !deb_tick |=> (deb_a == $past(deb_a) && deb_b == $past(deb_b)));

    // R9
    all_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_a == 4'd0 && mask_b == 4'd0 && mask_int == 3'd0) |-> !cpu_irq);
endmodule

bind irq_hub irq_hub_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .deb_tick (deb_tick),
    .set_a    (set_g[0]),
    .flags_a  (flags_g[0]),
    .flags_b  (flags_g[1]),
    .deb_a    (deb_g[0]),
    .deb_b    (deb_g[1]),
    .mask_a   (cfg[0].mask),
    .mask_b   (cfg[1].mask),
    .mask_int (mask_int),
    .cpu_irq  (cpu_irq)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       deb_tick = 1'b0;
    logic [3:0] pins_a = 4'd0;
    logic [3:0] pins_b = 4'd0;
    logic       tick_1hz = 1'b0, tick_8hz = 1'b0, tick_32hz = 1'b0;
    logic       timer_zero = 1'b0, sbuf_empty = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'd0, reg_wdata = 4'd0;
    logic [3:0] reg_rdata;
    logic       cpu_irq, wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_hub u0 (
        .clk(clk), .rst(rst), .deb_tick(deb_tick),
        .pins_a(pins_a), .pins_b(pins_b),
        .tick_1hz(tick_1hz), .tick_8hz(tick_8hz), .tick_32hz(tick_32hz),
        .timer_zero(timer_zero), .sbuf_empty(sbuf_empty),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic deb_pulse();
        @(negedge clk); deb_tick = 1'b1;
        @(negedge clk); deb_tick = 1'b0;
    endtask

    // 0:1hz 1:8hz 2:32hz 3:timer 4:sbuf
    task automatic src_pulse(input int which);
        @(negedge clk);
        case (which)
            0: tick_1hz = 1'b1;
            1: tick_8hz = 1'b1;
            2: tick_32hz = 1'b1;
            3: timer_zero = 1'b1;
            default: sbuf_empty = 1'b1;
        endcase
        @(negedge clk);
        tick_1hz = 1'b0; tick_8hz = 1'b0; tick_32hz = 1'b0;
        timer_zero = 1'b0; sbuf_empty = 1'b0;
    endtask

    function automatic logic [3:0] exp_edge(logic [3:0] old_v, logic [3:0] new_v, logic [3:0] pol);
        return (pol & old_v & ~new_v) | (~pol & new_v & ~old_v);
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] d;
        logic [3:0] prev_b;
        void'($urandom(32'd20240611));

        idle(3);
        rst = 1'b0;
        idle(1);

        // R1: reset values
        check("R1 cpu_irq", 32'(cpu_irq), 32'd0);
        check("R1 wake_req", 32'(wake_req), 32'd0);
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R1 reg reset", 32'(d), 32'd0);
        end

        // R11: register map read back, ignored writes
        wr(4'd4, 4'hA);  rd(4'd4, d);  check("R11 mask A", 32'(d), 32'hA);
        wr(4'd6, 4'hF);  rd(4'd6, d);  check("R11 mask int", 32'(d), 32'h7);
        wr(4'd9, 4'h5);  rd(4'd9, d);  check("R11 pol B", 32'(d), 32'h5);
        wr(4'd11, 4'h3); rd(4'd11, d); check("R11 deb B", 32'(d), 32'h3);
        wr(4'd12, 4'h2); rd(4'd12, d); check("R11 rate", 32'(d), 32'h2);
        wr(4'd3, 4'hF);  rd(4'd3, d);  check("R11 unused addr", 32'(d), 32'h0);
        wr(4'd0, 4'hF);  rd(4'd0, d);  check("R11 flag write ignored", 32'(d), 32'h0);
        wr(4'd4, 4'h0); wr(4'd6, 4'h0); wr(4'd9, 4'h0); wr(4'd11, 4'h0); wr(4'd12, 4'h0);

        // R2: direct edges, rising then falling polarity
        @(negedge clk); pins_a = 4'b0101; idle(3);
        rd(4'd0, d); check("R2 rising set", 32'(d), 32'h5);
        @(negedge clk); pins_a = 4'b0000; idle(3);
        rd(4'd0, d); check("R2 falling ignored", 32'(d), 32'h0);
        wr(4'd8, 4'hF);
        @(negedge clk); pins_a = 4'b0011; idle(3);
        rd(4'd0, d); check("R2 rising ignored when falling", 32'(d), 32'h0);
        @(negedge clk); pins_a = 4'b0000; idle(3);
        rd(4'd0, d); check("R2 falling set", 32'(d), 32'h3);
        wr(4'd8, 4'h0);

        // R4 / R5: sticky until read, read clears
        @(negedge clk); pins_a = 4'b1000; idle(20);
        rd(4'd0, d); check("R4 sticky", 32'(d), 32'h8);
        rd(4'd0, d); check("R5 cleared by read", 32'(d), 32'h0);

        // R9 / R10: masking
        @(negedge clk); pins_b = 4'b0110; idle(3);
        check("R9 all masked", 32'(cpu_irq), 32'd0);
        wr(4'd5, 4'b0100);
        check("R9 unmasked flag", 32'(cpu_irq), 32'd1);
        check("R10 wake follows", 32'(wake_req), 32'd1);
        wr(4'd5, 4'b1001);
        check("R9 other bits masked", 32'(cpu_irq), 32'd0);
        rd(4'd1, d); check("R9 masked flags latched", 32'(d), 32'h6);
        wr(4'd5, 4'h0);

        // R6: event in the cycle of a clearing read
        @(negedge clk); pins_a = 4'b1001; idle(3);
        @(negedge clk); pins_a = 4'b1011;
        rd(4'd0, d); check("R6 read shows old flag", 32'(d), 32'h1);
        rd(4'd0, d); check("R6 same-cycle event kept", 32'(d), 32'h2);

        // R7 / R8: internal sources and rate select
        wr(4'd6, 4'h7);
        src_pulse(0);
        check("R7 prescaler irq", 32'(cpu_irq), 32'd1);
        rd(4'd2, d); check("R8 1hz selected", 32'(d), 32'h1);
        check("R5 irq drops after read", 32'(cpu_irq), 32'd0);
        wr(4'd12, 4'd1);
        src_pulse(0); src_pulse(2);
        rd(4'd2, d); check("R8 unselected ticks ignored", 32'(d), 32'h0);
        src_pulse(1);
        rd(4'd2, d); check("R8 8hz selected", 32'(d), 32'h1);
        wr(4'd12, 4'd2);
        src_pulse(2);
        rd(4'd2, d); check("R8 32hz selected", 32'(d), 32'h1);
        wr(4'd12, 4'd3);
        src_pulse(0); src_pulse(1); src_pulse(2);
        rd(4'd2, d); check("R8 rate off", 32'(d), 32'h0);
        src_pulse(3);
        rd(4'd2, d); check("R7 timer bit1", 32'(d), 32'h2);
        src_pulse(4);
        rd(4'd2, d); check("R7 sbuf bit2", 32'(d), 32'h4);
        wr(4'd6, 4'h0);

        // R3: debounce on group A
        @(negedge clk); pins_a = 4'b0000; idle(3);
        rd(4'd0, d);
        wr(4'd10, 4'hF);
        @(negedge clk); pins_a = 4'b0001; idle(2);
        deb_pulse(); deb_pulse();
        @(negedge clk); pins_a = 4'b0000; idle(2);
        deb_pulse(); deb_pulse(); deb_pulse(); idle(3);
        rd(4'd0, d); check("R3 short glitch rejected", 32'(d), 32'h0);
        @(negedge clk); pins_a = 4'b0001; idle(2);
        deb_pulse(); deb_pulse(); idle(5);
        rd(4'd0, d); check("R3 two samples not enough", 32'(d), 32'h0);
        deb_pulse(); idle(3);
        rd(4'd0, d); check("R3 third sample accepts", 32'(d), 32'h1);

        // random: group B direct, random polarity and masks
        prev_b = pins_b;
        for (int it = 0; it < 60; it++) begin
            logic [3:0] pol, msk, nv, ex;
            pol = 4'($urandom);
            msk = 4'($urandom);
            nv  = 4'($urandom);
            wr(4'd9, pol);
            wr(4'd5, msk);
            @(negedge clk); pins_b = nv; idle(3);
            ex = exp_edge(prev_b, nv, pol);
            check("R9 random irq", 32'(cpu_irq), 32'(|(ex & msk)));
            check("R10 random wake", 32'(wake_req), 32'(|(ex & msk)));
            rd(4'd1, d); check("R2 random edges", 32'(d), 32'(ex));
            prev_b = nv;
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule